// File: doc/BRIEF.md
# I2C Sampling Converter Slave Front-End

This block is the bus side of a serial sampling converter. It watches a two-wire I2C-compatible bus and does one thing when it sees its own address: it starts a conversion in an attached converter core. While the core works, it holds the clock line low. It then returns the result to the master as two bytes. The master cannot write any registers. Whatever the direction bit in the address byte says, the transfer is always a read. That bit is passed to the core as a power hint instead.

The slave address is seven bits. The three upper bits are fixed and the four lower bits come from strap inputs, so up to sixteen of these slaves can share one bus. The master can keep the block converting back to back by acknowledging every low byte. A not-acknowledge ends the sequence. A master code moves the block into high-speed mode. The block answers that code with a deliberate not-acknowledge, keeps high-speed mode across repeated STARTs, and drops back to fast/standard mode at STOP.

The raw SCL and SDA pad inputs are resynchronised to a system clock. The system clock must run at least eight times faster than the fastest SCL. The outputs are open-drain pull-low enables for both lines, plus a start/done handshake to the converter core.

Top module: `i2c_conv_front`

## Requirements
- R1: The slave address is 7 bits: the upper three are 011 and the lower four are `addr_strap[3:0]`, sent MSB first. If the first byte after a START has any other address (and is not a master code), the block gives no acknowledge, issues no `conv_start`, and drives neither line until the next START.
- R2: When the address matches, the block pulls SDA low through the ninth clock, whatever the value of bit 0 of the byte. That bit appears on `conv_pwr_hint` from the acknowledge onward.
- R3: `scl_drive_low` rises in the same cycle as `conv_start`. It stays high until the cycle after `conv_done` is seen, and then falls. While SCL is stretched, SDA is not driven.
- R4: `conv_start` is a single-cycle pulse. It is issued 2 to 5 system clocks after the master's SCL falling edge that closes the acknowledge slot, and never earlier. That edge is the sampling instant.
- R5: The 16-bit converter word goes out MSB first. The first byte is word[15:8] (result bits 13..6). The second byte is word[7:0] (result bits 5..0 followed by sub-bits S1 and S0).
- R6: A master ACK after the second byte starts a new conversion, with SCL stretched again, followed by two more bytes. A master NACK after either byte releases both lines and ends the read.
- R7: `sda_drive_low` changes only in cycles where the synchronised SCL is low.
- R8: A first byte of the form 0000_1xxx is not acknowledged and sets `hs_mode` to 1. A following repeated START and read leave `hs_mode` at 1.
- R9: After reset, `hs_mode` is 0 (fast/standard mode) and no line is driven. A STOP clears `hs_mode` on the next cycle.
- R10: A STOP at any point, including in the middle of the address byte, returns the block to idle with both drive enables low. The next START and address then work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level from the pad |
| sda_in | input | 1 | Raw SDA line level from the pad |
| addr_strap | input | 4 | Strap value for the low four address bits |
| conv_done | input | 1 | One-cycle pulse from the core: result ready |
| conv_result | input | 16 | Result word, valid while conv_done is high |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_pwr_hint | output | 1 | Direction bit of the last matching address |
| hs_mode | output | 1 | 1 while in high-speed bus mode |

## Verification
Each bus edge reaches the state machine after the two synchroniser flops and is acted on one clock later. So `conv_start` appears three system clocks after the acknowledge-closing SCL fall, and the bench accepts a window of 2 to 5 clocks for it. The clock-stretch enable is compared on every falling system-clock edge against a behavioural converter model. That model expects the stretch in the cycle of `conv_start` and drops it one cycle after it has driven `conv_done`. Bytes, acknowledges and `hs_mode` are sampled at the middle of the SCL high phase or after a settled quarter period, never at the edge where they change.

// File: rtl/i2c_conv_pkg.sv
package i2c_conv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_CONV, ST_TX, ST_MACK, ST_HSNAK
  } bus_st_t;

  function automatic logic addr_hit(input logic [7:0] rx, input logic [2:0] fixed_hi,
                                    input logic [3:0] strap);
    return rx[7:1] == {fixed_hi, strap};
  endfunction

  function automatic logic is_hs_code(input logic [7:0] rx);
    return rx[7:3] == 5'b00001;
  endfunction
endpackage

// File: rtl/i2c_conv_sync.sv
module i2c_conv_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_conv_busmon.sv
module i2c_conv_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  i2c_conv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_in(scl_raw), .q_out(scl_s));
  i2c_conv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sda_raw), .q_out(sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_conv_fsm.sv
module i2c_conv_fsm
  import i2c_conv_pkg::*;
#(
  parameter int RES_W = 16,
  parameter logic [2:0] FIXED_HI = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [3:0]       strap,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             scl_low,
  output logic             sda_low,
  output logic             conv_start,
  output logic             pwr_hint,
  output logic             hs
);
  localparam int NBYTES = RES_W / 8;
  localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  bus_st_t          state;
  logic [3:0]       cnt;
  logic [7:0]       rx_byte;
  logic [RES_W-1:0] tx_word;
  logic [BI_W-1:0]  byte_idx;
  logic             master_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      rx_byte    <= '0;
      tx_word    <= '0;
      byte_idx   <= '0;
      master_ack <= 1'b0;
      scl_low    <= 1'b0;
      sda_low    <= 1'b0;
      conv_start <= 1'b0;
      pwr_hint   <= 1'b0;
      hs         <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (stop_evt) begin
        state   <= ST_IDLE;
        scl_low <= 1'b0;
        sda_low <= 1'b0;
        hs      <= 1'b0;
      end else if (start_evt) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        scl_low <= 1'b0;
        sda_low <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_byte <= {rx_byte[6:0], sda_s};
              cnt     <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_hit(rx_byte, FIXED_HI, strap)) begin
                sda_low  <= 1'b1;
                pwr_hint <= rx_byte[0];
                state    <= ST_ACK;
              end else if (is_hs_code(rx_byte)) begin
                state <= ST_HSNAK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_low    <= 1'b0;
              scl_low    <= 1'b1;
              conv_start <= 1'b1;
              state      <= ST_CONV;
            end
          end
          ST_CONV: begin
            if (conv_done) begin
              tx_word  <= conv_result;
              sda_low  <= ~conv_result[RES_W-1];
              scl_low  <= 1'b0;
              cnt      <= '0;
              byte_idx <= '0;
              state    <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              tx_word <= tx_word << 1;
              if (cnt == 4'd7) begin
                sda_low <= 1'b0;
                state   <= ST_MACK;
              end else begin
                sda_low <= ~tx_word[RES_W-2];
                cnt     <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (!master_ack) begin
                state <= ST_IDLE;
              end else if (byte_idx == BI_W'(NBYTES-1)) begin
                scl_low    <= 1'b1;
                conv_start <= 1'b1;
                state      <= ST_CONV;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                cnt      <= '0;
                sda_low  <= ~tx_word[RES_W-1];
                state    <= ST_TX;
              end
            end
          end
          ST_HSNAK: begin
            if (scl_fall) begin
              hs    <= 1'b1;
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
  AST_STRETCH_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> scl_low); // R3
  AST_NO_SDA_IN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> !sda_low); // R3
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_s); // R7
  AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hs); // R9
endmodule

// File: rtl/i2c_conv_front.sv
module i2c_conv_front #(
  parameter int SYNC_STAGES = 2,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [3:0]       addr_strap,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             conv_start,
  output logic             conv_pwr_hint,
  output logic             hs_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_conv_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2c_conv_fsm #(.RES_W(RES_W), .FIXED_HI(3'b011)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .strap(addr_strap),
    .conv_done(conv_done), .conv_result(conv_result),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low), .conv_start(conv_start),
    .pwr_hint(conv_pwr_hint), .hs(hs_mode));
endmodule

// File: tb/tb_i2c_conv_front.sv
module tb_i2c_conv_front;
  localparam int Q = 8;
  localparam int LAT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'b1010;
  logic conv_done = 1'b0;
  logic [15:0] conv_result = '0;
  logic scl_drive_low, sda_drive_low, conv_start, conv_pwr_hint, hs_mode;
  logic scl_line, sda_line;

  assign scl_line = scl_m & ~scl_drive_low;
  assign sda_line = sda_m & ~sda_drive_low;

  always #4 clk = ~clk;

  i2c_conv_front dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .addr_strap(strap), .conv_done(conv_done), .conv_result(conv_result),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .conv_start(conv_start), .conv_pwr_hint(conv_pwr_hint), .hs_mode(hs_mode));

  int checks = 0, fails = 0;
  int cyc = 0, last_fall = 0, start_cyc = -1, nstarts = 0, last_stretch = 0;
  bit finished = 1'b0;
  bit busy = 1'b0;
  int busy_cnt = 0;
  logic [15:0] conv_q[$];
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural converter core and every-clock stretch comparison (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(scl_drive_low == (busy || conv_start), "R3 stretch", scl_drive_low, busy || conv_start);
      if (scl_drive_low) chk(!sda_drive_low, "R3 sda idle in stretch", sda_drive_low, 0);
    end
    conv_done = 1'b0;
    if (conv_start && !busy) begin
      busy = 1'b1; busy_cnt = LAT; nstarts++; start_cyc = cyc;
    end else if (busy) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        conv_done = 1'b1;
        conv_result = (conv_q.size() > 0) ? conv_q.pop_front() : 16'h0;
        busy = 1'b0;
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    int st;
    @(negedge clk); sda_m = b;
    wq(Q);
    scl_m = 1'b1; #1;
    st = 0;
    while (!scl_line) begin @(negedge clk); #1; st++; end
    last_stretch = st;
    wq(Q);
    r = sda_line;
    wq(Q);
    scl_m = 1'b0; last_fall = cyc;
    wq(Q);
  endtask

  task automatic bus_start();
    @(negedge clk); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    @(negedge clk); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], r);
    clock_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v, output int stretch);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      v[i] = r;
      if (i == 7) stretch = last_stretch;
    end
    clock_bit(!mack, r);
  endtask

  // address + one or more conversions; checks bytes against the expected queue
  task automatic read_convs(input int n, input bit rw, input string tag);
    bit ack; logic [7:0] hi, lo; logic [15:0] e; int st, s0;
    s0 = nstarts;
    write_byte({7'h3A, rw}, ack);
    chk(ack, {tag, " R2 address ack"}, ack, 1);
    chk(start_cyc - last_fall >= 2 && start_cyc - last_fall <= 5,
        {tag, " R4 start delay after ack fall"}, start_cyc - last_fall, 3);
    chk(conv_pwr_hint == rw, {tag, " R2 power hint"}, conv_pwr_hint, rw);
    for (int k = 0; k < n; k++) begin
      e = exp_q.pop_front();
      read_byte(1'b1, hi, st);
      chk(st > 0, {tag, " R3 SCL stretched before data"}, st, 1);
      read_byte(k != n-1, lo, st);
      chk(hi == e[15:8], {tag, " R5 high byte"}, hi, e[15:8]);
      chk(lo == e[7:0], {tag, " R5 low byte"}, lo, e[7:0]);
    end
    chk(nstarts - s0 == n, {tag, " R6 conversion count"}, nstarts - s0, n);
    chk(!sda_drive_low && !scl_drive_low, {tag, " R6 released after NACK"},
        {sda_drive_low, scl_drive_low}, 0);
  endtask

  task automatic push_res(input logic [15:0] v);
    conv_q.push_back(v); exp_q.push_back(v);
  endtask

  initial begin
    bit ack; logic r; int s0;
    wq(4); rst_n = 1'b1; wq(4);
    chk(!hs_mode, "R9 reset mode", hs_mode, 0);
    chk(!scl_drive_low && !sda_drive_low && !conv_start, "R9 reset drives",
        {scl_drive_low, sda_drive_low, conv_start}, 0);

    // basic read, R/W=1
    push_res(16'hA5C3);
    bus_start(); read_convs(1, 1'b1, "T1"); bus_stop();
    // R/W=0 still reads
    push_res(16'h3FFD);
    bus_start(); read_convs(1, 1'b0, "T2"); bus_stop();
    // back to back, three conversions, edge patterns
    push_res(16'hFFFF); push_res(16'h0000); push_res(16'h8001);
    bus_start(); read_convs(3, 1'b1, "T3"); bus_stop();

    // R1 mismatch: wrong strap bits
    s0 = nstarts;
    bus_start(); write_byte({7'h3B, 1'b1}, ack);
    chk(!ack, "R1 mismatch no ack", ack, 0);
    wq(4*Q);
    chk(nstarts == s0, "R1 mismatch no conversion", nstarts - s0, 0);
    chk(!sda_drive_low && !scl_drive_low, "R1 mismatch no drive", {sda_drive_low, scl_drive_low}, 0);
    bus_stop();
    // R1 wrong fixed bits
    bus_start(); write_byte({7'h5A, 1'b1}, ack);
    chk(!ack, "R1 fixed bits mismatch", ack, 0);
    bus_stop();

    // R8 master code then repeated start read
    bus_start(); write_byte(8'h0D, ack);
    chk(!ack, "R8 master code NACK", ack, 0);
    wq(Q);
    chk(hs_mode, "R8 enters high-speed", hs_mode, 1);
    push_res(16'h1234);
    bus_start(); read_convs(1, 1'b1, "T8");
    chk(hs_mode, "R8 mode kept over repeated START", hs_mode, 1);
    bus_stop();
    chk(!hs_mode, "R9 STOP returns to fast mode", hs_mode, 0);

    // R10 STOP mid-address
    bus_start();
    clock_bit(1'b0, r); clock_bit(1'b1, r); clock_bit(1'b1, r);
    bus_stop();
    chk(!sda_drive_low && !scl_drive_low, "R10 idle after STOP", {sda_drive_low, scl_drive_low}, 0);
    push_res(16'h5AA6);
    bus_start(); read_convs(1, 1'b1, "T10"); bus_stop();

    // strap change to a different address
    strap = 4'b0101; wq(4);
    bus_start(); write_byte({7'h35, 1'b1}, ack);
    chk(ack, "R1 strap selects address", ack, 1);
    push_res(16'h0F0F);
    begin
      logic [7:0] hi, lo; int st;
      read_byte(1'b1, hi, st); read_byte(1'b0, lo, st);
      chk({hi, lo} == exp_q.pop_front(), "R5 strap read word", {hi, lo}, 16'h0F0F);
    end
    bus_stop();

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule